// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames into memory buffers named by a ring of descriptors. Each descriptor has a 16-bit status word, a 16-bit length and a 32-bit buffer address. Software prepares a descriptor by setting its EMPTY flag and clearing its length, and then pulses the activation input. The engine then reads the descriptor at its current ring position. If EMPTY is set, the engine keeps the buffer address and waits for a frame to start. It writes every frame byte to the buffer at consecutive addresses. When the frame ends, it writes the status and length back to the same descriptor. It then moves to the next descriptor, or back to the ring base when the descriptor just used carries WRAP, and reads that descriptor at once.

Incoming frames arrive as a byte stream with start, end and error markers. A frame that runs past the configured maximum length stops filling its buffer and is marked in error. If the engine reads a descriptor whose EMPTY flag is clear, it stalls. While stalled it drops all incoming traffic until software pulses the activation input again. The engine then reads the same descriptor again.

The descriptor read port returns the buffer address and the EMPTY and WRAP flags one cycle after a read request. The writeback port carries `{status, length}`. Status bit positions are EMPTY = 15, WRAP = 13, LAST = 11 and ERR = 0.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset the engine is stalled. It issues no descriptor read, descriptor write or buffer write until the activation input is pulsed.
- R2: A pulse on the activation input while stalled makes the engine issue a descriptor read on the next cycle. After reset this read is at the ring base index (parameter `RING_BASE`).
- R3: If a fetched descriptor has EMPTY (status bit 15) clear, the engine stalls. Frames that arrive while stalled cause no buffer write and no descriptor write. After the next activation pulse the engine reads the same descriptor index again.
- R4: Byte k of an accepted frame (k counted from 0 at the start-marked byte) is written to the descriptor's buffer address plus k.
- R5: At frame end the writeback status has EMPTY clear, LAST (bit 11) set and WRAP (bit 13) equal to its fetched value. ERR (bit 0) is clear for a good frame. The length equals the number of bytes in the frame, including the trailing check bytes.
- R6: After writing back a descriptor with WRAP set, the next read is at `RING_BASE`. Otherwise the next read is at the index plus one.
- R7: If the error marker is set on any byte of a frame, ERR is set in that frame's status.
- R8: A frame longer than `maxFrameLen` gets ERR set. Bytes at offsets `maxFrameLen` and above are not written. The stored length still counts every received byte.
- R9: Bytes that arrive while the engine waits for a frame, without the start marker, are ignored. They write nothing and do not change the next frame's offsets or length.
- R10: After a writeback the engine reads the next descriptor without any activation pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| kick | input | 1 | One-cycle pulse: descriptors have been made available |
| maxFrameLen | input | 16 | Maximum frame length in bytes |
| inValid | input | 1 | Byte valid on the frame stream |
| inData | input | 8 | Frame byte |
| inSof | input | 1 | First byte of a frame |
| inEof | input | 1 | Last byte of a frame |
| inErr | input | 1 | Frame flagged bad |
| descRd | output | 1 | Descriptor read request |
| descWr | output | 1 | Descriptor status/length write |
| descAddr | output | DESC_AW | Descriptor index for read or write |
| descRdPtr | input | 32 | Buffer address of the fetched descriptor, one cycle after descRd |
| descRdEmpty | input | 1 | EMPTY flag of the fetched descriptor |
| descRdWrap | input | 1 | WRAP flag of the fetched descriptor |
| descWrData | output | 32 | Writeback word: status in [31:16], length in [15:0] |
| bufWr | output | 1 | Buffer byte write |
| bufAddr | output | 32 | Buffer byte address |
| bufData | output | 8 | Buffer byte data |

## Verification
The hardest situation to reach is the engine wrapping onto a descriptor that software has not re-armed. It then stalls with traffic still arriving, and must read the same slot again after a fresh activation. To get there, the stimulus fills a three-slot ring whose last slot carries WRAP, using a frame that is too long. This lets the wrap and the over-length case happen on one descriptor. The engine then comes back to slot zero while that slot still holds a completed status. A frame is sent into the stall, and its buffer and descriptor contents are compared before and after re-arming. Stray bytes without a start marker are also sent into the waiting state just before a real frame.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int STAT_EMPTY = 15;
  localparam int STAT_WRAP  = 13;
  localparam int STAT_LAST  = 11;
  localparam int STAT_ERR   = 0;

  typedef enum logic [2:0] {
    S_STALL, S_FETCH, S_WAIT, S_READY, S_RECV, S_WB
  } ring_state_t;

  typedef struct packed {
    logic loadDesc;    // capture fetched pointer and wrap flag
    logic startFrame;  // first byte of a frame
    logic takeByte;    // continuation byte of a frame
    logic advance;     // step ring index
  } ring_strobe_t;
endpackage

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         kick,
  input  logic         inValid,
  input  logic         inSof,
  input  logic         inEof,
  input  logic         descRdEmpty,
  output ring_strobe_t strobe,
  output logic         descRd,
  output logic         descWr,
  output logic         stalled
);
  ring_state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_STALL;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    descRd    = 1'b0;
    descWr    = 1'b0;
    unique case (state)
      S_STALL: if (kick) stateNext = S_FETCH;
      S_FETCH: begin
        descRd    = 1'b1;
        stateNext = S_WAIT;
      end
      S_WAIT: begin
        if (descRdEmpty) begin
          strobe.loadDesc = 1'b1;
          stateNext       = S_READY;
        end else begin
          stateNext = S_STALL;
        end
      end
      S_READY: begin
        if (inValid && inSof) begin
          strobe.startFrame = 1'b1;
          stateNext         = inEof ? S_WB : S_RECV;
        end
      end
      S_RECV: begin
        if (inValid) begin
          strobe.takeByte = 1'b1;
          if (inEof) stateNext = S_WB;
        end
      end
      S_WB: begin
        descWr         = 1'b1;
        strobe.advance = 1'b1;
        stateNext      = S_FETCH;
      end
      default: stateNext = S_STALL;
    endcase
  end

  assign stalled = (state == S_STALL);
endmodule

// File: rtl/rx_ring_dp.sv
module rx_ring_dp
  import rx_ring_pkg::*;
#(
  parameter int DESC_AW   = 4,
  parameter int RING_BASE = 0,
  parameter int LEN_W     = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ring_strobe_t       strobe,
  input  logic [LEN_W-1:0]   maxFrameLen,
  input  logic [7:0]         inData,
  input  logic               inErr,
  input  logic [31:0]        descRdPtr,
  input  logic               descRdWrap,
  output logic [DESC_AW-1:0] descAddr,
  output logic [31:0]        descWrData,
  output logic               bufWr,
  output logic [31:0]        bufAddr,
  output logic [7:0]         bufData
);
  localparam logic [DESC_AW-1:0] BASE_IDX = DESC_AW'(RING_BASE);
  localparam logic [LEN_W-1:0]   CNT_MAX  = '1;

  logic [DESC_AW-1:0] curIdx;
  logic [31:0]        bufPtr;
  logic               wrapBit;
  logic [LEN_W-1:0]   byteCnt;
  logic               errFlag;
  logic               tooLong;

  logic               byteIn;
  logic [LEN_W-1:0]   curOff;
  logic [LEN_W-1:0]   nextCnt;
  logic               fits;
  logic [15:0]        wbStatus;

  assign byteIn  = strobe.startFrame | strobe.takeByte;
  assign curOff  = strobe.startFrame ? '0 : byteCnt;
  assign nextCnt = (curOff == CNT_MAX) ? curOff : curOff + 1'b1;
  assign fits    = curOff < maxFrameLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx  <= BASE_IDX;
      bufPtr  <= '0;
      wrapBit <= 1'b0;
      byteCnt <= '0;
      errFlag <= 1'b0;
      tooLong <= 1'b0;
    end else begin
      if (strobe.loadDesc) begin
        bufPtr  <= descRdPtr;
        wrapBit <= descRdWrap;
      end
      if (byteIn) begin
        byteCnt <= nextCnt;
        errFlag <= (strobe.startFrame ? 1'b0 : errFlag) | inErr;
        tooLong <= (strobe.startFrame ? 1'b0 : tooLong) | ~fits;
      end
      if (strobe.advance)
        curIdx <= wrapBit ? BASE_IDX : curIdx + 1'b1;
    end
  end

  always_comb begin
    wbStatus             = '0;
    wbStatus[STAT_EMPTY] = 1'b0;
    wbStatus[STAT_WRAP]  = wrapBit;
    wbStatus[STAT_LAST]  = 1'b1;
    wbStatus[STAT_ERR]   = errFlag | tooLong;
  end

  assign descAddr   = curIdx;
  assign descWrData = {wbStatus, 16'(byteCnt)};
  assign bufWr      = byteIn & fits;
  assign bufAddr    = bufPtr + 32'(curOff);
  assign bufData    = inData;
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
  import rx_ring_pkg::*;
#(
  parameter int DESC_AW   = 4,
  parameter int RING_BASE = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               kick,
  input  logic [15:0]        maxFrameLen,
  input  logic               inValid,
  input  logic [7:0]         inData,
  input  logic               inSof,
  input  logic               inEof,
  input  logic               inErr,
  output logic               descRd,
  output logic               descWr,
  output logic [DESC_AW-1:0] descAddr,
  input  logic [31:0]        descRdPtr,
  input  logic               descRdEmpty,
  input  logic               descRdWrap,
  output logic [31:0]        descWrData,
  output logic               bufWr,
  output logic [31:0]        bufAddr,
  output logic [7:0]         bufData
);
  ring_strobe_t strobe;
  logic         isStalled;

  rx_ring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .kick(kick),
    .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .descRdEmpty(descRdEmpty),
    .strobe(strobe), .descRd(descRd), .descWr(descWr),
    .stalled(isStalled)
  );

  rx_ring_dp #(.DESC_AW(DESC_AW), .RING_BASE(RING_BASE), .LEN_W(16)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .maxFrameLen(maxFrameLen), .inData(inData), .inErr(inErr),
    .descRdPtr(descRdPtr), .descRdWrap(descRdWrap),
    .descAddr(descAddr), .descWrData(descWrData),
    .bufWr(bufWr), .bufAddr(bufAddr), .bufData(bufData)
  );
endmodule

// File: rtl/rx_ring_chk.sv
module rx_ring_chk #(
  parameter int DESC_AW   = 4,
  parameter int RING_BASE = 0
) (
  input logic               clk,
  input logic               rstN,
  input logic               kick,
  input logic               stalled,
  input logic               descRd,
  input logic               descWr,
  input logic [DESC_AW-1:0] descAddr,
  input logic [31:0]        descWrData,
  input logic               bufWr
);
  // R1/R3: a stalled engine touches no memory
  p_stall_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    stalled |-> (!bufWr && !descWr));

  // R2: activation while stalled triggers a descriptor read
  p_kick_fetch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stalled && kick) |=> descRd);

  // R5: writeback releases the descriptor and marks frame end
  p_wb_flags_r5: assert property (@(posedge clk) disable iff (!rstN)
    descWr |-> (!descWrData[31] && descWrData[27] && !descRd));

  // R10: writeback is followed at once by the next fetch
  p_fetch_after_wb_r10: assert property (@(posedge clk) disable iff (!rstN)
    descWr |=> descRd);

  // R6: wrap returns to the base index
  p_wrap_base_r6: assert property (@(posedge clk) disable iff (!rstN)
    (descWr && descWrData[29]) |=> (descAddr == DESC_AW'(RING_BASE)));

  // R6: no wrap steps the index by one
  p_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (descWr && !descWrData[29]) |=> (descAddr == $past(descAddr) + 1'b1));
endmodule

bind rx_ring_engine rx_ring_chk #(.DESC_AW(DESC_AW), .RING_BASE(RING_BASE)) u_chk (
  .clk(clk), .rstN(rstN), .kick(kick), .stalled(isStalled),
  .descRd(descRd), .descWr(descWr), .descAddr(descAddr),
  .descWrData(descWrData), .bufWr(bufWr)
);

// File: tb/sim_rx_ring_engine.sv
module sim_rx_ring_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic kick = 1'b0;
  logic [15:0] maxFrameLen = 16'd1518;
  logic inValid = 1'b0, inSof = 1'b0, inEof = 1'b0, inErr = 1'b0;
  logic [7:0] inData = '0;
  logic descRd, descWr, bufWr;
  logic [AW-1:0] descAddr;
  logic [31:0] descRdPtr, descWrData, bufAddr;
  logic descRdEmpty, descRdWrap;
  logic [7:0] bufData;

  // bench-side memories
  logic [15:0] dStat [0:15];
  logic [15:0] dLen  [0:15];
  logic [31:0] dPtr  [0:15];
  logic [7:0]  bmem  [0:255];
  int rdCount = 0, wrCount = 0;
  int lastRdAddr = -1;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_engine #(.DESC_AW(AW), .RING_BASE(0)) u0 (
    .clk(clk), .rstN(rstN), .kick(kick), .maxFrameLen(maxFrameLen),
    .inValid(inValid), .inData(inData), .inSof(inSof), .inEof(inEof), .inErr(inErr),
    .descRd(descRd), .descWr(descWr), .descAddr(descAddr),
    .descRdPtr(descRdPtr), .descRdEmpty(descRdEmpty), .descRdWrap(descRdWrap),
    .descWrData(descWrData), .bufWr(bufWr), .bufAddr(bufAddr), .bufData(bufData)
  );

  always @(posedge clk) begin
    if (descRd) begin
      descRdPtr   <= dPtr[descAddr];
      descRdEmpty <= dStat[descAddr][15];
      descRdWrap  <= dStat[descAddr][13];
      rdCount     <= rdCount + 1;
      lastRdAddr  <= int'(descAddr);
    end
    if (descWr) begin
      dStat[descAddr] <= descWrData[31:16];
      dLen[descAddr]  <= descWrData[15:0];
    end
    if (bufWr) begin
      bmem[bufAddr[7:0]] <= bufData;
      wrCount <= wrCount + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulseKick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendFrame(input int n, input int v0, input int errAt, input bit withSof);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b1; inData = 8'(v0 + i);
      inSof = withSof && (i == 0);
      inEof = withSof && (i == n - 1);
      inErr = (i == errAt);
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0; inErr = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic checkBytes(input string tag, input int base, input int n, input int v0);
    int errs = 0;
    for (int i = 0; i < n; i++)
      if (bmem[base + i] !== 8'(v0 + i)) errs++;
    check(tag, errs, 0);
  endtask

  task automatic testReset();
    repeat (6) @(negedge clk);
    check("R1 no reads after reset", rdCount, 0);
    check("R1 no buffer writes after reset", wrCount, 0);
  endtask

  task automatic testGoodFrame();
    pulseKick();
    check("R2 first fetch at ring base", lastRdAddr, 0);
    sendFrame(8, 8'h10, -1, 1'b1);
    checkBytes("R4 frame bytes in buffer 0", 8'h00, 8, 8'h10);
    check("R5 good status", int'(dStat[0]), 16'h0800);
    check("R5 length", int'(dLen[0]), 8);
    check("R10 next fetch without kick", lastRdAddr, 1);
  endtask

  task automatic testErrFrame();
    sendFrame(5, 8'h20, 3, 1'b1);
    check("R7 error status", int'(dStat[1]), 16'h0801);
    check("R7 error length", int'(dLen[1]), 5);
    checkBytes("R4 bytes in buffer 1", 8'h40, 5, 8'h20);
  endtask

  task automatic testLongWrap();
    maxFrameLen = 16'd20;
    sendFrame(24, 8'h30, -1, 1'b1);
    check("R8 overlong status with wrap", int'(dStat[2]), 16'h2801);
    check("R8 full length kept", int'(dLen[2]), 24);
    checkBytes("R8 bytes up to limit", 8'h80, 20, 8'h30);
    check("R8 no write past limit", int'(bmem[8'h80 + 20]), 8'hEE);
    check("R6 wrap returns to base", lastRdAddr, 0);
    maxFrameLen = 16'd1518;
  endtask

  task automatic testStall();
    int w0, r0;
    w0 = wrCount;
    sendFrame(6, 8'h70, -1, 1'b1);
    check("R3 no buffer write while stalled", wrCount, w0);
    check("R3 descriptor untouched", int'(dStat[0]), 16'h0800);
    check("R3 length untouched", int'(dLen[0]), 8);
    dStat[0] = 16'h8000; dLen[0] = 16'd0;
    r0 = rdCount;
    pulseKick();
    check("R3 refetch after kick", rdCount, r0 + 1);
    check("R3 refetch same index", lastRdAddr, 0);
    sendFrame(4, 8'h50, -1, 1'b1);
    check("R3 frame after rearm", int'(dStat[0]), 16'h0800);
    check("R3 length after rearm", int'(dLen[0]), 4);
    checkBytes("R4 bytes after rearm", 8'h00, 4, 8'h50);
  endtask

  task automatic testStray();
    check("R3 stalls on used slot 1", lastRdAddr, 1);
    dStat[1] = 16'h8000; dLen[1] = 16'd0;
    pulseKick();
    sendFrame(3, 8'h99, -1, 1'b0);
    sendFrame(5, 8'h60, -1, 1'b1);
    check("R9 stray bytes ignored status", int'(dStat[1]), 16'h0800);
    check("R9 stray bytes ignored length", int'(dLen[1]), 5);
    checkBytes("R9 frame at offset zero", 8'h40, 5, 8'h60);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 8'hEE;
    for (int i = 0; i < 16; i++) begin
      dStat[i] = 16'h0000; dLen[i] = 16'd0; dPtr[i] = 32'(i * 64);
    end
    dStat[0] = 16'h8000; dStat[1] = 16'h8000; dStat[2] = 16'hA000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testGoodFrame();
    testErrFrame();
    testLongWrap();
    testStall();
    testStray();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule